// File: doc/BRIEF.md
# First/Next Error Logging Unit

This unit gathers single-cycle error pulses from a number of sources and keeps a record of them in two sticky registers. The first register holds the error, or the group of errors, that arrived while nothing was yet recorded there. The second register collects everything that arrives after that. Each source has an enable bit. A disabled source is dropped before it reaches any register. A summary status bit tells the link status path that some error is on record.

Each source is also tagged as either alert-class or status-only. An enabled alert-class error raises an in-band alert request towards the link transmitter, using a valid/ready handshake. The first alert that arrives while the log is unlocked copies that source's data word into a log register and locks the log. The log stays frozen until software has cleared every alert-class bit in both registers. Software clears bits with write-one-to-clear strobes, and the strobes for the two registers are separate.

The alert request is the only stream-like interface. `alert_valid` rises the cycle after an enabled alert-class error and stays high until a cycle with `alert_ready` high. Alerts that arrive while a request is already pending merge into that request. If a new alert arrives in the same cycle as a handshake, the request stays high for one more round. All other pins are plain levels or strobes.

Top module: `err_log_unit`

## Requirements
- R1: When the first register is zero after this cycle's clears are applied, every enabled error pulsing in that cycle sets its bit in the first register, all bits together. Bit i stands for source i.
- R2: When the first register is non-zero after this cycle's clears, enabled errors set their bits in the next register, and the first register is not changed by them.
- R3: A 1 on bit i of `clr_first` or `clr_next` clears bit i of that register at the next edge. Once the first register has been cleared to zero, the next error is recorded as a first error again.
- R4: If a new error and a clear hit the same bit of the register that the error is routed to, in the same cycle, the bit stays set.
- R5: An error on a source whose `err_en` bit is 0 changes no output. This covers both registers, the status bit, the alert request and the log.
- R6: `err_status` is 1 exactly when any bit of either register is set.
- R7: `alert_valid` rises one cycle after an enabled error whose `err_is_alert` bit is 1. Status-only errors (class bit 0) never raise it.
- R8: `alert_valid` stays high while `alert_ready` is low. It falls after a cycle with `alert_ready` high, unless a new enabled alert arrives in that same cycle.
- R9: When the log is unlocked and enabled alert errors arrive, the log captures the data word and index of the lowest-indexed of those alert sources, and `log_locked` goes to 1. The data word for source i is `err_log_in[i*LOG_W +: LOG_W]`.
- R10: While `log_locked` is 1, `log_data` and `log_src` do not change.
- R11: The log unlocks when no alert-class bit remains in either register. An alert arriving in the same cycle as the clear of the last alert bit is captured as a fresh first alert.
- R12: After reset, both registers, `err_status`, `alert_valid`, `log_locked`, `log_data` and `log_src` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_in | input | N_ERR | Error pulses, one per source |
| err_en | input | N_ERR | Per-source enable (1 = recorded) |
| err_is_alert | input | N_ERR | Per-source class (1 = alert, 0 = status-only) |
| err_log_in | input | N_ERR*LOG_W | Data word of each source, packed by index |
| clr_first | input | N_ERR | Write-one-to-clear strobe for the first register |
| clr_next | input | N_ERR | Write-one-to-clear strobe for the next register |
| first_err | output | N_ERR | First-error register |
| next_err | output | N_ERR | Next-error register |
| err_status | output | 1 | Summary error bit |
| alert_valid | output | 1 | In-band alert request |
| alert_ready | input | 1 | Link has taken the alert request |
| log_locked | output | 1 | Log register is frozen |
| log_data | output | LOG_W | Captured data word |
| log_src | output | $clog2(N_ERR) | Index of the captured source |

## Verification
A table of single-cycle vectors drives the recording path with several patterns. It starts with simultaneous errors into an empty first register, then adds later errors one at a time, then clears the first register to zero so that routing falls back to it. Two vectors put a clear and a set in the same cycle, one on the first register and one on the next register. This separates "first register empty before the clears" from "empty after them", and "clear wins" from "set wins". Directed cases test several further behaviours. A fully disabled burst and a partly disabled burst show the mask works per source. A status-only pulse is contrasted with an alert pulse. A handshake that coincides with a new alert tells the two hold rules apart. Changing the data seed between alerts shows whether the locked log is ever rewritten, and simultaneous alerts show which index wins.

// File: rtl/err_log_pkg.sv
package err_log_pkg;
  localparam int DEF_N_ERR = 8;
  localparam int DEF_LOG_W = 16;

  // Where the enabled errors of a cycle are recorded
  typedef enum logic {
    ROUTE_FIRST = 1'b0,
    ROUTE_NEXT  = 1'b1
  } route_e;
endpackage

// File: rtl/err_record.sv
module err_record
  import err_log_pkg::*;
#(
  parameter int N_ERR = DEF_N_ERR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ERR-1:0] hit,
  input  logic [N_ERR-1:0] clr_first,
  input  logic [N_ERR-1:0] clr_next,
  output logic [N_ERR-1:0] first_q,
  output logic [N_ERR-1:0] next_q,
  output logic [N_ERR-1:0] first_kept,
  output logic [N_ERR-1:0] next_kept
);
  route_e route;
  logic [N_ERR-1:0] first_d, next_d;

  always_comb begin
    first_kept = first_q & ~clr_first;
    next_kept  = next_q & ~clr_next;
    route      = (first_kept == '0) ? ROUTE_FIRST : ROUTE_NEXT;
    first_d    = first_kept | ((route == ROUTE_FIRST) ? hit : '0);
    next_d     = next_kept  | ((route == ROUTE_NEXT)  ? hit : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      next_q  <= '0;
    end else begin
      first_q <= first_d;
      next_q  <= next_d;
    end
  end
endmodule

// File: rtl/err_prio_pick.sv
module err_prio_pick #(
  parameter int N_ERR = 8,
  parameter int IDX_W = 3
) (
  input  logic [N_ERR-1:0] req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N_ERR - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/err_log_capture.sv
module err_log_capture #(
  parameter int N_ERR = 8,
  parameter int LOG_W = 16,
  parameter int IDX_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic               lock_d,
  input  logic [IDX_W-1:0]   src_idx,
  input  logic [N_ERR*LOG_W-1:0] log_in,
  output logic               locked,
  output logic [LOG_W-1:0]   log_data,
  output logic [IDX_W-1:0]   log_src
);
  logic [LOG_W-1:0] slot [N_ERR];

  for (genvar g = 0; g < N_ERR; g++) begin : g_slot
    assign slot[g] = log_in[g*LOG_W +: LOG_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      log_data <= '0;
      log_src  <= '0;
    end else begin
      locked <= lock_d;
      if (capture) begin
        log_data <= slot[src_idx];
        log_src  <= src_idx;
      end
    end
  end
endmodule

// File: rtl/err_alert_req.sv
module err_alert_req (
  input  logic clk,
  input  logic rst_n,
  input  logic new_alert,
  input  logic ready,
  output logic valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= (valid & ~ready) | new_alert;
  end
endmodule

// File: rtl/err_log_unit.sv
module err_log_unit
  import err_log_pkg::*;
#(
  parameter int N_ERR = DEF_N_ERR,
  parameter int LOG_W = DEF_LOG_W,
  localparam int IDX_W = (N_ERR > 1) ? $clog2(N_ERR) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_ERR-1:0]       err_in,
  input  logic [N_ERR-1:0]       err_en,
  input  logic [N_ERR-1:0]       err_is_alert,
  input  logic [N_ERR*LOG_W-1:0] err_log_in,
  input  logic [N_ERR-1:0]       clr_first,
  input  logic [N_ERR-1:0]       clr_next,
  output logic [N_ERR-1:0]       first_err,
  output logic [N_ERR-1:0]       next_err,
  output logic                   err_status,
  output logic                   alert_valid,
  input  logic                   alert_ready,
  output logic                   log_locked,
  output logic [LOG_W-1:0]       log_data,
  output logic [IDX_W-1:0]       log_src
);
  logic [N_ERR-1:0] hit, alert_hit, first_kept, next_kept;
  logic             any_alert, alert_left, capture, lock_d;
  logic [IDX_W-1:0] pick_idx;

  assign hit       = err_in & err_en;
  assign alert_hit = hit & err_is_alert;

  err_record #(.N_ERR(N_ERR)) u_record (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit        (hit),
    .clr_first  (clr_first),
    .clr_next   (clr_next),
    .first_q    (first_err),
    .next_q     (next_err),
    .first_kept (first_kept),
    .next_kept  (next_kept)
  );

  err_prio_pick #(.N_ERR(N_ERR), .IDX_W(IDX_W)) u_pick (
    .req   (alert_hit),
    .found (any_alert),
    .idx   (pick_idx)
  );

  // Alert bits still on record once this cycle's clears are applied
  assign alert_left = |((first_kept | next_kept) & err_is_alert);
  assign capture    = any_alert & ~alert_left;
  assign lock_d     = any_alert | alert_left;

  err_log_capture #(.N_ERR(N_ERR), .LOG_W(LOG_W), .IDX_W(IDX_W)) u_log (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture),
    .lock_d   (lock_d),
    .src_idx  (pick_idx),
    .log_in   (err_log_in),
    .locked   (log_locked),
    .log_data (log_data),
    .log_src  (log_src)
  );

  err_alert_req u_alert (
    .clk       (clk),
    .rst_n     (rst_n),
    .new_alert (any_alert),
    .ready     (alert_ready),
    .valid     (alert_valid)
  );

  assign err_status = |(first_err | next_err);
endmodule

// File: rtl/err_log_unit_chk.sv
module err_log_unit_chk #(
  parameter int N_ERR = 8,
  parameter int LOG_W = 16,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_ERR-1:0] err_in,
  input logic [N_ERR-1:0] err_en,
  input logic [N_ERR-1:0] err_is_alert,
  input logic [N_ERR-1:0] clr_first,
  input logic [N_ERR-1:0] clr_next,
  input logic [N_ERR-1:0] first_err,
  input logic [N_ERR-1:0] next_err,
  input logic             err_status,
  input logic             alert_valid,
  input logic             alert_ready,
  input logic             log_locked,
  input logic [LOG_W-1:0] log_data,
  input logic [IDX_W-1:0] log_src
);
  AST_FIRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (first_err != '0 && clr_first == '0) |=> first_err == $past(first_err)); // R2

  AST_MASKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_in & err_en) == '0 && clr_first == '0 && clr_next == '0)
      |=> ($stable(first_err) && $stable(next_err))); // R5

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_status && clr_first == '0 && clr_next == '0) |=> err_status); // R6

  AST_ALERT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(err_in & err_en & err_is_alert)) |=> alert_valid); // R7

  AST_ALERT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_valid && !alert_ready) |=> alert_valid); // R8

  AST_LOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(log_locked) |-> $past(|(err_in & err_en & err_is_alert))); // R9

  AST_LOG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (log_locked && clr_first == '0 && clr_next == '0)
      |=> ($stable(log_data) && $stable(log_src))); // R10
endmodule

bind err_log_unit err_log_unit_chk #(.N_ERR(N_ERR), .LOG_W(LOG_W), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .err_in       (err_in),
  .err_en       (err_en),
  .err_is_alert (err_is_alert),
  .clr_first    (clr_first),
  .clr_next     (clr_next),
  .first_err    (first_err),
  .next_err     (next_err),
  .err_status   (err_status),
  .alert_valid  (alert_valid),
  .alert_ready  (alert_ready),
  .log_locked   (log_locked),
  .log_data     (log_data),
  .log_src      (log_src)
);

// File: tb/test_err_log_unit.sv
`timescale 1ns/1ps
module test_err_log_unit;
  localparam int N = 8;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  err_in = '0, err_en = '1, err_is_alert = 8'hF0;
  logic [N-1:0]  clr_first = '0, clr_next = '0;
  logic [N*LW-1:0] err_log_in;
  logic [N-1:0]  first_err, next_err;
  logic          err_status, alert_valid, log_locked;
  logic          alert_ready = 1'b0;
  logic [LW-1:0] log_data;
  logic [2:0]    log_src;
  logic [7:0]    seed = 8'h00;
  int            n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) err_log_in[i*LW +: LW] = {seed, 8'(i * 17)};

  err_log_unit #(.N_ERR(N), .LOG_W(LW)) i_err_log_unit (
    .clk(clk), .rst_n(rst_n), .err_in(err_in), .err_en(err_en),
    .err_is_alert(err_is_alert), .err_log_in(err_log_in),
    .clr_first(clr_first), .clr_next(clr_next), .first_err(first_err),
    .next_err(next_err), .err_status(err_status), .alert_valid(alert_valid),
    .alert_ready(alert_ready), .log_locked(log_locked), .log_data(log_data),
    .log_src(log_src));

  // {err, clr_first, clr_next, expected first, expected next}
  localparam logic [39:0] VEC [10] = '{
    40'h03_00_00_03_00, 40'h04_00_00_03_04, 40'h01_00_00_03_05,
    40'h00_03_00_00_05, 40'h08_00_00_08_05, 40'h10_08_00_10_05,
    40'h04_00_04_10_05, 40'h00_00_05_10_00, 40'h00_10_00_00_00,
    40'h00_00_00_00_00};

  function automatic logic [LW-1:0] word(input int i, input logic [7:0] s);
    return {s, 8'(i * 17)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle of stimulus, released 1 ns after the capturing edge
  task automatic cyc(input logic [N-1:0] e, input logic [N-1:0] cf,
                     input logic [N-1:0] cn, input logic rdy);
    @(negedge clk);
    err_in = e; clr_first = cf; clr_next = cn; alert_ready = rdy;
    @(posedge clk);
    #1;
    err_in = '0; clr_first = '0; clr_next = '0; alert_ready = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1;
    chk("R12 reset first", 32'(first_err), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset next", 32'(next_err), 0);
    chk("R12 reset status/alert/lock", {err_status, alert_valid, log_locked}, 0);
    chk("R12 reset log", {log_data, 5'd0, log_src}, 0);

    // Table: R1/R2/R3/R4 with R6 status
    alert_ready = 1'b1;
    for (int v = 0; v < 10; v++) begin
      cyc(VEC[v][39:32], VEC[v][31:24], VEC[v][23:16], 1'b1);
      chk("R1/R2/R3/R4 first", 32'(first_err), 32'(VEC[v][15:8]));
      chk("R1/R2/R3/R4 next", 32'(next_err), 32'(VEC[v][7:0]));
      chk("R6 status", 32'(err_status), 32'(|VEC[v][15:0]));
    end
    repeat (2) cyc('0, '0, '0, 1'b1);
    chk("R11 table leaves log unlocked", 32'(log_locked), 0);

    // R5: masked sources
    err_en = 8'h00;
    cyc(8'hFF, '0, '0, 1'b0);
    chk("R5 full mask regs", {first_err, next_err}, 0);
    chk("R5 full mask status/alert/lock", {err_status, alert_valid, log_locked}, 0);
    err_en = 8'hFE;
    cyc(8'h03, '0, '0, 1'b0);
    chk("R5 partial mask", 32'(first_err), 32'h02);
    cyc('0, 8'h02, '0, 1'b0);
    err_en = 8'hFF;

    // R7/R9: first alert captures, lowest index wins
    seed = 8'h5A;
    cyc(8'h20, '0, '0, 1'b0);
    chk("R7 alert raised", 32'(alert_valid), 1);
    chk("R9 locked", 32'(log_locked), 1);
    chk("R9 log data", 32'(log_data), 32'(word(5, 8'h5A)));
    chk("R9 log src", 32'(log_src), 5);
    repeat (2) cyc('0, '0, '0, 1'b0);
    chk("R8 held without ready", 32'(alert_valid), 1);
    cyc('0, '0, '0, 1'b1);
    chk("R8 drop after handshake", 32'(alert_valid), 0);

    // R10: later alerts leave the log alone
    seed = 8'hC3;
    cyc(8'h80, '0, '0, 1'b0);
    chk("R2 alert into next", 32'(next_err), 32'h80);
    chk("R10 log data frozen", 32'(log_data), 32'(word(5, 8'h5A)));
    chk("R10 log src frozen", 32'(log_src), 5);
    cyc(8'h40, '0, '0, 1'b1);
    chk("R8 handshake with new alert keeps valid", 32'(alert_valid), 1);
    cyc('0, 8'h20, '0, 1'b1);
    chk("R11 still locked with next alert bits", 32'(log_locked), 1);
    chk("R8 released", 32'(alert_valid), 0);

    // R11: alert in the cycle the last alert bit is cleared
    seed = 8'h77;
    cyc(8'h80, '0, 8'hC0, 1'b0);
    chk("R11 recapture src", 32'(log_src), 7);
    chk("R11 recapture data", 32'(log_data), 32'(word(7, 8'h77)));
    chk("R4/R11 routed to first", {first_err, next_err}, 32'h8000);
    cyc('0, 8'h80, '0, 1'b1);
    chk("R11 unlocked", 32'(log_locked), 0);
    chk("R6 status clear", 32'(err_status), 0);

    // R9: simultaneous alerts pick the lowest index
    seed = 8'h11;
    cyc(8'hC0, '0, '0, 1'b1);
    chk("R9 lowest src", 32'(log_src), 6);
    chk("R1 both bits first", 32'(first_err), 32'hC0);
    cyc('0, 8'hC0, '0, 1'b1);
    chk("R8 handshake done", 32'(alert_valid), 0);

    // R7: status-only error never raises alert or lock
    cyc(8'h01, '0, '0, 1'b0);
    chk("R7 status-only no alert", {alert_valid, log_locked}, 0);
    chk("R7 status-only recorded", 32'(first_err), 32'h01);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule